// File: doc/BRIEF.md
# Lock-step three-stage valid-tagged pipeline

This block passes a stream of 16-bit words through three fixed arithmetic steps. The first step adds one. The second doubles the result. The third XORs it with a constant. The steps are split by two pipeline registers, and each register carries a valid tag. Words enter through a ready/valid handshake and leave through another one. All stages move together. In any cycle, either the whole pipeline shifts forward by one slot or nothing moves.

The pipeline shifts when the sink accepts data or when the last register holds no word. A slot with no word in it (a bubble) travels forward like data. It is dropped at the output without producing a transfer. A sink that stalls while a word waits at the output freezes the whole pipeline and holds off the source.

Top module: `lockstep_pipe`

## Requirements
- R1: `in_ready_o` is high exactly when `out_ready_i` is high or `out_valid_o` is low. This is the single advance condition for all stages.
- R2: A word x accepted at the input (`in_valid_i` and `in_ready_o` both high) later appears on `out_data_o` as ((x + 1) * 2) XOR `KEY`, taken modulo 2^16. The default `KEY` is 16'hA5C3.
- R3: In a cycle where the pipeline advances with `in_valid_i` low, a bubble enters. Two advances later, `out_valid_o` is low.
- R4: Words leave in the order they were accepted. None is lost or duplicated, and `out_valid_o` is high only while the last register holds a word.
- R5: While `out_valid_o` is high and `out_ready_i` is low, `in_ready_o` is low and no input is consumed. In the next cycle, `out_valid_o` is still high and `out_data_o` is unchanged.
- R6: A bubble in the last register lets the pipeline advance even while `out_ready_i` is low. Starting from empty with the sink stalled, two words are accepted before `in_ready_o` drops.
- R7: While `rst_ni` is low, `out_valid_o` is low. After reset is released, `in_ready_o` is high.
- R8: With no stall, a word accepted in cycle c is presented on the output in cycle c+2. In cycle c+1, `out_valid_o` is still low.
- R9: `out_valid_o` reflects stage 1's valid tag of the cycle before whenever the pipeline advanced in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears both valid tags |
| in_valid_i | input | 1 | Source offers a word |
| in_ready_o | output | 1 | Pipeline advances this cycle; the offered word is taken |
| in_data_i | input | W | Input word |
| out_valid_o | output | 1 | Last register holds a word |
| out_ready_i | input | 1 | Sink takes the word this cycle |
| out_data_o | output | W | Result of the third step applied to the last register |

## Verification
`in_ready_o` depends combinationally on `out_ready_i` and the last valid tag, so the bench checks it in the same cycle the inputs are driven. Each accepted word produces an expected result that is queued in the bench. That result is compared when the output handshake completes, which is two cycles after acceptance when there is no stall. The directed latency test checks that `out_valid_o` is low one cycle after acceptance, high with the value two cycles after, and low again one cycle later because of the trailing bubble. Stall checks compare the held output in the cycle after a refused transfer.

// File: rtl/lockstep_pipe_pkg.sv
package lockstep_pipe_pkg;
  typedef enum logic [1:0] {
    OP_INC = 2'd0,
    OP_DBL = 2'd1,
    OP_XOR = 2'd2
  } stage_op_e;

  localparam int NUM_REGS = 2;
endpackage

// File: rtl/lp_stage_fn.sv
module lp_stage_fn
  import lockstep_pipe_pkg::*;
#(
  parameter int          W   = 16,
  parameter stage_op_e   OP  = OP_INC,
  parameter logic [W-1:0] KEY = '0
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  generate
    if (OP == OP_INC) begin : g_inc
      assign y_o = a_i + W'(1);
    end else if (OP == OP_DBL) begin : g_dbl
      assign y_o = {a_i[W-2:0], 1'b0};
    end else begin : g_xor
      assign y_o = a_i ^ KEY;
    end
  endgenerate
endmodule

// File: rtl/lp_stage_reg.sv
module lp_stage_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         v_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    v_o <= 1'b0;
    else if (adv_i) v_o <= v_i;
  end

  // data needs no reset; qualified by v_o
  always_ff @(posedge clk_i) begin
    if (adv_i && load_i) d_o <= d_i;
  end
endmodule

// File: rtl/lp_adv_ctrl.sv
module lp_adv_ctrl (
  input  logic out_ready_i,
  input  logic tail_v_i,
  output logic adv_o
);
  // shift when sink takes data or tail slot is a bubble
  assign adv_o = out_ready_i | ~tail_v_i;
endmodule

// File: rtl/lockstep_pipe.sv
module lockstep_pipe
  import lockstep_pipe_pkg::*;
#(
  parameter int           W   = 16,
  parameter logic [W-1:0] KEY = 16'hA5C3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  localparam int LAST = NUM_REGS - 1;

  logic                adv;
  logic [NUM_REGS-1:0] v_q;
  logic [W-1:0]        d_q   [NUM_REGS];
  logic [W-1:0]        fn_y  [NUM_REGS];

  lp_adv_ctrl u_adv (
    .out_ready_i (out_ready_i),
    .tail_v_i    (v_q[LAST]),
    .adv_o       (adv)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_stage
      if (i == 0) begin : g_head
        lp_stage_fn #(.W(W), .OP(OP_INC), .KEY(KEY)) u_fn (
          .a_i (in_data_i),
          .y_o (fn_y[i])
        );
        lp_stage_reg #(.W(W)) u_reg (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .adv_i  (adv),
          .v_i    (in_valid_i),
          .load_i (in_valid_i),
          .d_i    (fn_y[i]),
          .v_o    (v_q[i]),
          .d_o    (d_q[i])
        );
      end else begin : g_body
        lp_stage_fn #(.W(W), .OP(OP_DBL), .KEY(KEY)) u_fn (
          .a_i (d_q[i-1]),
          .y_o (fn_y[i])
        );
        lp_stage_reg #(.W(W)) u_reg (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .adv_i  (adv),
          .v_i    (v_q[i-1]),
          .load_i (1'b1),
          .d_i    (fn_y[i]),
          .v_o    (v_q[i]),
          .d_o    (d_q[i])
        );
      end
    end
  endgenerate

  lp_stage_fn #(.W(W), .OP(OP_XOR), .KEY(KEY)) u_fn_out (
    .a_i (d_q[LAST]),
    .y_o (out_data_o)
  );

  assign in_ready_o  = adv;
  assign out_valid_o = v_q[LAST];
endmodule

// File: rtl/lockstep_pipe_chk.sv
module lockstep_pipe_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] out_data_o,
  input logic         s1_v_i
);
  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R5
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // R6
  squeeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> s1_v_i);

  // R3
  bubble_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> !s1_v_i);

  // R9
  tag_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> out_valid_o == $past(s1_v_i));
endmodule

bind lockstep_pipe lockstep_pipe_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .s1_v_i      (v_q[0])
);

// File: tb/test_lockstep_pipe.sv
module test_lockstep_pipe;
  localparam int          W   = 16;
  localparam logic [15:0] KEY = 16'hA5C3;

  typedef struct packed {
    logic [15:0] data;
    logic        gap;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{16'h0000, 1'b0, 1'b0}, '{16'h0001, 1'b0, 1'b0},
    '{16'hFFFF, 1'b1, 1'b0}, '{16'h7FFF, 1'b0, 1'b1},
    '{16'h8000, 1'b0, 1'b1}, '{16'h1234, 1'b1, 1'b1},
    '{16'hA5C3, 1'b0, 1'b0}, '{16'h5A3C, 1'b0, 1'b1},
    '{16'hFFFE, 1'b1, 1'b0}, '{16'h00FF, 1'b0, 1'b0},
    '{16'hBEEF, 1'b0, 1'b1}, '{16'hC0DE, 1'b1, 1'b1},
    '{16'h4000, 1'b0, 1'b0}, '{16'h0F0F, 1'b1, 1'b0},
    '{16'hD00D, 1'b0, 1'b1}, '{16'h2468, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [W-1:0]  in_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b1;
  logic [W-1:0]  out_data_o;

  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  logic [15:0]   exp_q [$];
  logic          hold_pend = 1'b0;
  logic [15:0]   held;
  logic          acc;
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  lockstep_pipe #(.W(W), .KEY(KEY)) i_lockstep_pipe (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o)
  );

  function automatic logic [15:0] model(input logic [15:0] x);
    logic [15:0] t;
    t = x + 16'd1;
    return {t[14:0], 1'b0} ^ KEY;
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample();
    #1;
    check(in_ready_o === (out_ready_i || !out_valid_o), "R1 in_ready",
          16'(in_ready_o), 16'(out_ready_i || !out_valid_o));
    if (hold_pend) begin
      check(out_valid_o === 1'b1, "R5 held valid", 16'(out_valid_o), 16'd1);
      check(out_data_o === held, "R5 held data", out_data_o, held);
    end
    hold_pend = out_valid_o && !out_ready_i;
    held      = out_data_o;
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) check(1'b0, "R4 extra output", out_data_o, 16'h0000);
      else begin
        check(out_data_o === exp_q[0], "R2 R4 output value/order", out_data_o, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    acc = in_valid_i && in_ready_o;
    if (acc) exp_q.push_back(model(in_data_i));
  endtask

  task automatic advance();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sample();
      advance();
    end
    check(exp_q.size() == 0, "R4 all words delivered", 16'(exp_q.size()), 16'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL timeout R4 actual=%0d expected<20000", cyc);
      report();
    end
  end

  initial begin
    // R7: reset state
    #1;
    check(out_valid_o === 1'b0, "R7 out_valid in reset", 16'(out_valid_o), 16'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(in_ready_o === 1'b1, "R7 in_ready after reset", 16'(in_ready_o), 16'd1);
    check(out_valid_o === 1'b0, "R7 out_valid after reset", 16'(out_valid_o), 16'd0);
    @(negedge clk);

    // vector table walk
    for (int v = 0; v < 16; v++) begin
      if (VECS[v].gap) begin
        in_valid_i  = 1'b0;
        out_ready_i = 1'b1;
        sample();
        advance();
      end
      in_valid_i  = 1'b1;
      in_data_i   = VECS[v].data;
      out_ready_i = !VECS[v].stall;
      acc = 1'b0;
      for (int t = 0; t < 6 && !acc; t++) begin
        sample();
        advance();
        out_ready_i = 1'b1;
      end
    end
    drain();

    // R8 latency and R3 trailing bubble
    in_valid_i = 1'b1;
    in_data_i  = 16'h0042;
    sample();
    check(acc === 1'b1, "R8 accepted", 16'(acc), 16'd1);
    advance();
    in_valid_i = 1'b0;
    sample();
    check(out_valid_o === 1'b0, "R8 not yet at c+1", 16'(out_valid_o), 16'd0);
    advance();
    sample();
    check(out_valid_o === 1'b1, "R8 valid at c+2", 16'(out_valid_o), 16'd1);
    check(out_data_o === model(16'h0042), "R8 value at c+2", out_data_o, model(16'h0042));
    advance();
    sample();
    check(out_valid_o === 1'b0, "R3 bubble follows", 16'(out_valid_o), 16'd0);
    advance();

    // R6 squeeze from empty with sink stalled, then R5 freeze
    out_ready_i = 1'b0;
    in_valid_i  = 1'b1;
    in_data_i   = 16'h1111;
    sample();
    check(in_ready_o === 1'b1, "R6 first take", 16'(in_ready_o), 16'd1);
    advance();
    in_data_i = 16'h2222;
    sample();
    check(in_ready_o === 1'b1, "R6 second take", 16'(in_ready_o), 16'd1);
    advance();
    in_data_i = 16'h3333;
    for (int k = 0; k < 3; k++) begin
      sample();
      check(in_ready_o === 1'b0, "R5 blocked", 16'(in_ready_o), 16'd0);
      check(out_data_o === model(16'h1111), "R5 head held", out_data_o, model(16'h1111));
      advance();
    end
    out_ready_i = 1'b1;
    acc = 1'b0;
    for (int t = 0; t < 4 && !acc; t++) begin
      sample();
      advance();
    end
    drain();

    // random stalls on both sides
    for (int k = 0; k < 400; k++) begin
      lfsr        = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready_i = lfsr[0] | lfsr[3];
      if (!in_valid_i || acc) begin
        in_valid_i = lfsr[5] | lfsr[7];
        in_data_i  = lfsr ^ 16'(k);
      end
      sample();
      advance();
    end
    drain();

    report();
  end
endmodule